// File: doc/BRIEF.md
# Tagged Quad-Word Memory Controller

This block wraps a small storage array and keeps one hidden tag bit for every tag granule of that storage. The tag marks a granule as holding an intact pointer-like value. The tag is held in its own flop bank beside the data, in the way spare check bits would be, and is never part of the addressable bytes. Any ordinary store that touches a byte of a granule silently drops that granule's tag. Only a quad-word store can set a tag, and only a quad-word load can report it, and both work this way only while the tags-active mode input is high. With the mode low, quad accesses act as plain accesses: the store clears the tags and the load reports no tag.

There is one request port. Each request carries a byte address, write data, byte enables, a store flag and a quad flag. Storage is organised as rows of `ROW_BYTES` bytes, and a quad access covers one whole row. A quad address must be row aligned. A misaligned quad request is refused: it raises a one-cycle alignment error and changes nothing. Loads answer one cycle after the request. The response carries the data, a tag bit and a tag-valid strobe. A request is classified as idle, plain load, plain store, quad load, tagged quad load, quad store, tagged quad store or misaligned. A response state register then takes one of five states: IDLE, READ_PLAIN, READ_TAGGED, WROTE or FAULT. Every cycle it moves to the state that matches the class of the current request. A plain load or an untagged quad load leads to READ_PLAIN, a tagged quad load to READ_TAGGED, any accepted store to WROTE, a misaligned quad request to FAULT, and no request to IDLE. The response strobes are decoded from that state alone.

Top module: `tagmem_ctrl`

## Requirements
- R1: After reset every tag bit is 0, and rd_vld, tag_out_vld, align_err and tag_out are low. The data array holds no defined contents after reset.
- R2: A plain store (req_quad=0) writes each byte whose req_be bit is set into row req_addr[ADDR_W-1:4]. It ignores the offset bits req_addr[3:0]. It clears the tag of every granule in which at least one req_be bit is set. A plain store with req_be all zero leaves the data and the tag unchanged.
- R3: An aligned quad store (req_addr[3:0]=0) with tags_active=1 writes all ROW_BYTES bytes and ignores req_be. It sets every granule tag of the row to tag_in.
- R4: An aligned quad store with tags_active=0 writes all bytes of the row and clears every granule tag of the row to 0.
- R5: An aligned quad load with tags_active=1 returns, one cycle later, rd_vld=1, the row data and tag_out_vld=1. In the same cycle tag_out is the AND of all granule tags of the row.
- R6: An aligned quad load with tags_active=0 returns rd_vld=1 and the row data one cycle later, with tag_out_vld=0 and tag_out=0.
- R7: A plain load returns rd_vld=1 and the row data one cycle later, with tag_out_vld=0 and tag_out=0, and leaves every tag unchanged.
- R8: A quad request with req_addr[3:0] not zero raises align_err for exactly the next cycle, with rd_vld=0 and tag_out_vld=0. Neither data nor tags change.
- R9: A load issued in the cycle right after a store to the same row returns the newly written data and tag.
- R10: A cycle with req_vld=0 produces rd_vld=0, tag_out_vld=0 and align_err=0 in the following cycle, and changes no tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_vld | input | 1 | A request is presented this cycle |
| req_wr | input | 1 | 1 = store, 0 = load |
| req_quad | input | 1 | 1 = quad-word (whole row) access, 0 = plain access |
| req_addr | input | ADDR_W | Byte address; the upper bits select the row |
| req_wdata | input | ROW_BYTES*8 | Store data, byte b at bits 8b+7:8b |
| req_be | input | ROW_BYTES | Byte enables for plain stores |
| tags_active | input | 1 | Tags-active mode bit |
| tag_in | input | 1 | Tag value written by a tagged quad store |
| rd_vld | output | 1 | Load response valid |
| rd_data | output | ROW_BYTES*8 | Load response data |
| tag_out | output | 1 | Row tag, meaningful when tag_out_vld is high |
| tag_out_vld | output | 1 | Tag response valid (tagged quad load only) |
| align_err | output | 1 | One-cycle pulse for a refused misaligned quad request |

## Verification
The assertions assume that req_vld is low while reset is held. They also assume that req_wr, req_quad, req_addr and tags_active are stable and known whenever req_vld is high, so the class decoded in a cycle matches what the port showed. The bench drives every input on the falling edge and holds req_vld low through reset, so each request is seen by exactly one rising edge. It reads a row's data only after writing that row, so no data comparison depends on the undefined contents of the array.

// File: rtl/tmw_pkg.sv
package tmw_pkg;

    // Classification of the request presented in the current cycle.
    typedef enum logic [2:0] {
        CL_NONE,
        CL_NLOAD,
        CL_NSTORE,
        CL_QLOAD,
        CL_QLOAD_T,
        CL_QSTORE,
        CL_QSTORE_T,
        CL_MISALIGN
    } req_class_t;

    // Response state: what the block reports in the cycle after a request.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ_PLAIN,
        ST_READ_TAGGED,
        ST_WROTE,
        ST_FAULT
    } rsp_state_t;

endpackage

// File: rtl/tmw_classify.sv
module tmw_classify
    import tmw_pkg::*;
#(
    parameter int ROW_BYTES     = 16,
    parameter int GRANULE_BYTES = 16,
    parameter int OFF_W         = $clog2(ROW_BYTES),
    parameter int GPR           = ROW_BYTES / GRANULE_BYTES
) (
    input  logic                 req_vld,
    input  logic                 req_wr,
    input  logic                 req_quad,
    input  logic [OFF_W-1:0]     req_off,
    input  logic [ROW_BYTES-1:0] req_be,
    input  logic                 tags_active,
    output req_class_t           cls,
    output logic [GPR-1:0]       touch_mask
);

    // Decode the request into one class.
    always_comb begin
        cls = CL_NONE;
        if (req_vld) begin
            if (req_quad && (req_off != '0)) begin
                cls = CL_MISALIGN;
            end else if (req_quad) begin
                if (req_wr) cls = tags_active ? CL_QSTORE_T : CL_QSTORE;
                else        cls = tags_active ? CL_QLOAD_T  : CL_QLOAD;
            end else begin
                cls = req_wr ? CL_NSTORE : CL_NLOAD;
            end
        end
    end

    // A granule is touched when any of its byte enables is set.
    for (genvar g = 0; g < GPR; g++) begin : g_touch
        assign touch_mask[g] = |req_be[g*GRANULE_BYTES +: GRANULE_BYTES];
    end

endmodule

// File: rtl/tmw_data_array.sv
module tmw_data_array #(
    parameter int DEPTH     = 16,
    parameter int ROW_BYTES = 16,
    parameter int ROW_W     = $clog2(DEPTH),
    parameter int DW        = ROW_BYTES * 8
) (
    input  logic                 clk,
    input  logic                 wr_en,
    input  logic [ROW_W-1:0]     wr_row,
    input  logic [ROW_BYTES-1:0] wr_be,
    input  logic [DW-1:0]        wr_data,
    input  logic                 rd_en,
    input  logic [ROW_W-1:0]     rd_row,
    output logic [DW-1:0]        rd_data
);

    // Storage needs no reset; only the tags must start cleared.
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            for (int b = 0; b < ROW_BYTES; b++) begin
                if (wr_be[b]) mem[wr_row][b*8 +: 8] <= wr_data[b*8 +: 8];
            end
        end
    end

    // Registered read: one cycle of latency, and it sees prior-cycle writes.
    always_ff @(posedge clk) begin
        if (rd_en) rd_data <= mem[rd_row];
    end

endmodule

// File: rtl/tmw_tag_array.sv
module tmw_tag_array #(
    parameter int DEPTH = 16,
    parameter int GPR   = 1,
    parameter int ROW_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             upd_en,
    input  logic [ROW_W-1:0] upd_row,
    input  logic [GPR-1:0]   clr_mask,
    input  logic             set_en,
    input  logic             set_val,
    input  logic             rd_en,
    input  logic [ROW_W-1:0] rd_row,
    output logic             rd_tag
);

    logic [GPR-1:0] tags [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int r = 0; r < DEPTH; r++) tags[r] <= '0;
            rd_tag <= 1'b0;
        end else begin
            if (upd_en) begin
                for (int g = 0; g < GPR; g++) begin
                    if (set_en)           tags[upd_row][g] <= set_val;
                    else if (clr_mask[g]) tags[upd_row][g] <= 1'b0;
                end
            end
            // The row is tagged only when every granule in it is intact.
            if (rd_en) rd_tag <= &tags[rd_row];
        end
    end

    for (genvar r = 0; r < DEPTH; r++) begin : g_chk
        assert_clear_touched_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (upd_en && !set_en && upd_row == ROW_W'(r))
            |=> ((tags[r] & $past(clr_mask)) == '0));
        assert_set_from_in_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (upd_en && set_en && upd_row == ROW_W'(r))
            |=> (tags[r] == {GPR{$past(set_val)}}));
        assert_hold_no_update_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (!upd_en) |=> $stable(tags[r]));
    end

endmodule

// File: rtl/tagmem_ctrl.sv
module tagmem_ctrl
    import tmw_pkg::*;
#(
    parameter int DEPTH         = 16,
    parameter int ROW_BYTES     = 16,
    parameter int GRANULE_BYTES = 16,
    parameter int ADDR_W        = $clog2(DEPTH * ROW_BYTES)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_vld,
    input  logic                   req_wr,
    input  logic                   req_quad,
    input  logic [ADDR_W-1:0]      req_addr,
    input  logic [ROW_BYTES*8-1:0] req_wdata,
    input  logic [ROW_BYTES-1:0]   req_be,
    input  logic                   tags_active,
    input  logic                   tag_in,
    output logic                   rd_vld,
    output logic [ROW_BYTES*8-1:0] rd_data,
    output logic                   tag_out,
    output logic                   tag_out_vld,
    output logic                   align_err
);

    localparam int OFF_W = $clog2(ROW_BYTES);
    localparam int ROW_W = ADDR_W - OFF_W;
    localparam int GPR   = ROW_BYTES / GRANULE_BYTES;

    req_class_t     cls;
    logic [GPR-1:0] touch_mask;
    rsp_state_t     state_q, state_d;
    logic [ROW_W-1:0] row;
    logic           is_store, is_load, is_quad_store;
    logic [ROW_BYTES-1:0] wr_be;
    logic [GPR-1:0] clr_mask;
    logic           tag_rd;

    assign row = req_addr[ADDR_W-1:OFF_W];

    tmw_classify #(
        .ROW_BYTES(ROW_BYTES), .GRANULE_BYTES(GRANULE_BYTES),
        .OFF_W(OFF_W), .GPR(GPR)
    ) u_cls (
        .req_vld(req_vld), .req_wr(req_wr), .req_quad(req_quad),
        .req_off(req_addr[OFF_W-1:0]), .req_be(req_be),
        .tags_active(tags_active), .cls(cls), .touch_mask(touch_mask)
    );

    always_comb begin
        is_quad_store = (cls == CL_QSTORE) || (cls == CL_QSTORE_T);
        is_store      = is_quad_store || (cls == CL_NSTORE);
        is_load       = (cls == CL_NLOAD) || (cls == CL_QLOAD) || (cls == CL_QLOAD_T);
        wr_be         = is_quad_store ? '1 : req_be;
        clr_mask      = is_quad_store ? '1 : touch_mask;
    end

    tmw_data_array #(
        .DEPTH(DEPTH), .ROW_BYTES(ROW_BYTES), .ROW_W(ROW_W)
    ) u_data (
        .clk(clk), .wr_en(is_store), .wr_row(row), .wr_be(wr_be),
        .wr_data(req_wdata), .rd_en(is_load), .rd_row(row), .rd_data(rd_data)
    );

    tmw_tag_array #(
        .DEPTH(DEPTH), .GPR(GPR), .ROW_W(ROW_W)
    ) u_tag (
        .clk(clk), .rst_n(rst_n), .upd_en(is_store), .upd_row(row),
        .clr_mask(clr_mask), .set_en(cls == CL_QSTORE_T), .set_val(tag_in),
        .rd_en(is_load), .rd_row(row), .rd_tag(tag_rd)
    );

    // Next response state: taken from the class of this cycle's request.
    always_comb begin
        unique case (cls)
            CL_NLOAD, CL_QLOAD:                state_d = ST_READ_PLAIN;
            CL_QLOAD_T:                        state_d = ST_READ_TAGGED;
            CL_NSTORE, CL_QSTORE, CL_QSTORE_T: state_d = ST_WROTE;
            CL_MISALIGN:                       state_d = ST_FAULT;
            default:                           state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Outputs are decoded from the response state alone.
    always_comb begin
        rd_vld      = 1'b0;
        tag_out_vld = 1'b0;
        tag_out     = 1'b0;
        align_err   = 1'b0;
        unique case (state_q)
            ST_READ_PLAIN:  rd_vld = 1'b1;
            ST_READ_TAGGED: begin
                rd_vld      = 1'b1;
                tag_out_vld = 1'b1;
                tag_out     = tag_rd;
            end
            ST_FAULT:       align_err = 1'b1;
            default:        ;
        endcase
    end

    assert_tagvld_with_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && !req_wr && req_quad && tags_active && req_addr[OFF_W-1:0] == '0)
        |=> (rd_vld && tag_out_vld));
    assert_untagged_quad_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && !req_wr && req_quad && !tags_active && req_addr[OFF_W-1:0] == '0)
        |=> (rd_vld && !tag_out_vld && !tag_out));
    assert_plain_load_notag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && !req_wr && !req_quad) |=> (rd_vld && !tag_out_vld && !tag_out));
    assert_misalign_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && req_quad && req_addr[OFF_W-1:0] != '0)
        |=> (align_err && !rd_vld && !tag_out_vld));
    assert_err_one_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (align_err && !(req_vld && req_quad && req_addr[OFF_W-1:0] != '0)) |=> !align_err);
    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_vld) |=> (!rd_vld && !tag_out_vld && !align_err));
    assert_strobes_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rd_vld, align_err}));

endmodule

// File: tb/sim_tagmem_ctrl.sv
module sim_tagmem_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 16;
    localparam int RB    = 16;
    localparam int AW    = 8;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           req_vld = 1'b0, req_wr = 1'b0, req_quad = 1'b0;
    logic [AW-1:0]  req_addr = '0;
    logic [RB*8-1:0] req_wdata = '0;
    logic [RB-1:0]  req_be = '0;
    logic           tags_active = 1'b0, tag_in = 1'b0;
    logic           rd_vld, tag_out, tag_out_vld, align_err;
    logic [RB*8-1:0] rd_data;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;

    // Bench model, built from the requirements.
    logic [RB*8-1:0] m_mem [DEPTH];
    logic            m_tag [DEPTH];
    logic            e_rd, e_tv, e_tag, e_err;
    logic [RB*8-1:0] e_data;

    tagmem_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_wr(req_wr),
        .req_quad(req_quad), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_be(req_be), .tags_active(tags_active), .tag_in(tag_in),
        .rd_vld(rd_vld), .rd_data(rd_data), .tag_out(tag_out),
        .tag_out_vld(tag_out_vld), .align_err(align_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=%0d expected<=5000", cycles);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    task automatic check(input string req, input logic [RB*8-1:0] act, input logic [RB*8-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one request at a falling edge and capture the response one cycle later.
    task automatic do_op(input bit wr, input bit quad, input logic [AW-1:0] addr,
                         input logic [RB*8-1:0] data, input logic [RB-1:0] be,
                         input bit mode, input bit tin);
        int  row = int'(addr[AW-1:4]);
        bit  mis = quad && (addr[3:0] != 4'd0);
        req_vld = 1'b1; req_wr = wr; req_quad = quad; req_addr = addr;
        req_wdata = data; req_be = be; tags_active = mode; tag_in = tin;
        e_rd  = !wr && !mis;
        e_tv  = !wr && quad && mode && !mis;
        e_tag = e_tv ? m_tag[row] : 1'b0;
        e_err = mis;
        e_data = m_mem[row];
        if (wr && !mis) begin
            for (int b = 0; b < RB; b++)
                if (quad || be[b]) m_mem[row][b*8 +: 8] = data[b*8 +: 8];
            if (quad)      m_tag[row] = mode ? tin : 1'b0;
            else if (|be)  m_tag[row] = 1'b0;
        end
        @(negedge clk);
        req_vld = 1'b0;
    endtask

    task automatic check_rsp(input string req, input bit with_data);
        check({req, " rd_vld"}, {127'b0, rd_vld}, {127'b0, e_rd});
        check({req, " tag_out_vld"}, {127'b0, tag_out_vld}, {127'b0, e_tv});
        check({req, " tag_out"}, {127'b0, tag_out}, {127'b0, e_tag});
        check({req, " align_err"}, {127'b0, align_err}, {127'b0, e_err});
        if (with_data) check({req, " rd_data"}, rd_data, e_data);
    endtask

    function automatic logic [AW-1:0] ra(input int row, input int off);
        return AW'(row * RB + off);
    endfunction

    task automatic t_reset();
        check("R1 rd_vld", {127'b0, rd_vld}, '0);
        check("R1 tag_out_vld", {127'b0, tag_out_vld}, '0);
        check("R1 align_err", {127'b0, align_err}, '0);
        do_op(0, 1, ra(7, 0), '0, '0, 1, 0);
        check_rsp("R1 tag after reset", 0);
    endtask

    task automatic t_tagged_quad();
        do_op(1, 1, ra(2, 0), {4{32'hCAFE_0002}}, 16'h0001, 1, 1);
        do_op(0, 1, ra(2, 0), '0, '0, 1, 0);
        check_rsp("R3 R5 R9 tagged quad round trip", 1);
        do_op(1, 1, ra(3, 0), {4{32'h1234_5678}}, '0, 1, 0);
        do_op(0, 1, ra(3, 0), '0, '0, 1, 0);
        check_rsp("R3 tagged store of zero tag", 1);
    endtask

    task automatic t_plain_store_clears();
        do_op(1, 1, ra(4, 0), {4{32'hAAAA_5555}}, '0, 1, 1);
        do_op(1, 0, ra(4, 0), '0, 16'h0000, 0, 0);
        do_op(0, 1, ra(4, 0), '0, '0, 1, 0);
        check_rsp("R2 empty byte enable keeps tag", 1);
        do_op(1, 0, ra(4, 9), {16{8'h3C}}, 16'h0100, 0, 0);
        do_op(0, 1, ra(4, 0), '0, '0, 1, 0);
        check_rsp("R2 one byte store clears tag", 1);
    endtask

    task automatic t_mode_off();
        do_op(1, 1, ra(5, 0), {4{32'h0BAD_F00D}}, '0, 1, 1);
        do_op(1, 1, ra(5, 0), {4{32'h7777_1111}}, '0, 0, 1);
        do_op(0, 1, ra(5, 0), '0, '0, 0, 0);
        check_rsp("R6 quad load with mode clear", 1);
        do_op(0, 1, ra(5, 0), '0, '0, 1, 0);
        check_rsp("R4 quad store with mode clear drops tag", 1);
    endtask

    task automatic t_plain_load();
        do_op(1, 1, ra(6, 0), {4{32'h6666_6666}}, '0, 1, 1);
        do_op(0, 0, ra(6, 3), '0, '0, 1, 0);
        check_rsp("R7 plain load reports no tag", 1);
        do_op(0, 1, ra(6, 0), '0, '0, 1, 0);
        check_rsp("R7 tag kept after plain load", 1);
    endtask

    task automatic t_misalign();
        do_op(1, 1, ra(8, 0), {4{32'h8888_0008}}, '0, 1, 1);
        do_op(1, 1, ra(8, 4), {4{32'hDEAD_DEAD}}, '0, 1, 0);
        check_rsp("R8 misaligned quad store", 0);
        do_op(0, 1, ra(8, 8), '0, '0, 1, 0);
        check_rsp("R8 misaligned quad load", 0);
        @(negedge clk);
        check("R8 error lasts one cycle", {127'b0, align_err}, '0);
        do_op(0, 1, ra(8, 0), '0, '0, 1, 0);
        check_rsp("R8 row untouched after refusal", 1);
    endtask

    task automatic t_idle();
        @(negedge clk);
        check("R10 idle rd_vld", {127'b0, rd_vld}, '0);
        check("R10 idle align_err", {127'b0, align_err}, '0);
        do_op(0, 1, ra(2, 0), '0, '0, 1, 0);
        check_rsp("R10 tag unchanged over idle", 1);
    endtask

    initial begin
        for (int r = 0; r < DEPTH; r++) m_tag[r] = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_tagged_quad();
        t_plain_store_clears();
        t_mode_off();
        t_plain_load();
        t_misalign();
        t_idle();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule